// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is the operand shifter of a 32-bit RISC execute stage. It takes a 32-bit operand and a 3-bit shift kind. For the variable shifts it also takes an 8-bit amount from 0 to 255, and for the immediate rotate it takes a 4-bit rotate field. It also takes the current carry flag. It returns the shifted value and the carry-out that a flag-setting logical instruction would commit.

The kinds are left shift, logical right shift, arithmetic right shift, rotate right, rotate-right-extended through the carry, and an immediate rotate whose amount is twice the 4-bit field. Every boundary rule is built in: an amount of zero, an amount of exactly the word width, amounts beyond it, and rotates by a nonzero multiple of the word width. An elaboration parameter places an optional register on the outputs for timing. With the register absent, the block is purely combinational.

Top module: `shf_barrel`

## Requirements
- R1: For kinds LSL (0), LSR (1), ASR (2) and ROR (3), an amount of 0 returns the operand unchanged and returns the incoming carry as the carry-out.
- R2: LSL with an amount n from 1 to 32 returns the operand shifted left by n, which is all zeros at n = 32. The carry-out is operand bit 32−n.
- R3: LSL or LSR with an amount above 32 returns zero with a carry-out of zero.
- R4: LSR with an amount n from 1 to 32 returns the operand shifted right with zero fill, which is all zeros at n = 32. The carry-out is operand bit n−1, so it is bit 31 at n = 32.
- R5: ASR with an amount n from 1 to 31 sign-extends and returns operand bit n−1 as the carry-out. With n of 32 or more, every result bit and the carry-out equal operand bit 31.
- R6: ROR rotates right by the amount modulo 32, and the carry-out is bit 31 of the returned value. A nonzero amount that is a multiple of 32 returns the operand unchanged, with operand bit 31 as the carry-out.
- R7: RRX (kind 4) returns the operand shifted right by one with the incoming carry in bit 31, and the old bit 0 as the carry-out. The 8-bit amount has no effect.
- R8: The immediate rotate (kind 5) rotates right by twice the 4-bit field, and the 8-bit amount has no effect. For a nonzero rotate r, the carry-out is operand bit r−1. A zero field returns the operand and the incoming carry.
- R9: Kind codes 6 and 7 return the operand and the incoming carry unchanged.
- R10: With OUT_REG = 1, which is the default, both outputs are registered. They show the result of the inputs present at the previous rising clock edge, and they read zero while or after synchronous active-high reset. With OUT_REG = 0 the outputs follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opnd_i | input | 32 | Operand to shift |
| kind_i | input | 3 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX, 5 immediate rotate, 6/7 pass |
| amt_i | input | 8 | Shift amount 0 to 255 for kinds 0 to 3 |
| rot_fld_i | input | 4 | Immediate rotate field; rotate amount is twice its value |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | Carry-out |

## Verification
Each kind is driven with every amount from 0 to 40 and with 255. Each amount is tried against a lone-bit operand, a pattern with both edge bits set, a positive pattern, an all-ones word, and random words, and each combination is run with both carry values. The single-bit and edge-bit operands show whether the carry comes from the correct bit index at 1, 31, 32 and 33. The negative and positive operands separate sign fill from zero fill. The two carry values show where the incoming carry must survive: at amount zero, for a zero immediate field, in RRX bit 31, and in the pass codes. The immediate rotate is swept over all sixteen field values, with a random 8-bit amount present to show that the amount is ignored.

// File: rtl/shf_pkg.sv
package shf_pkg;

    localparam int unsigned SHF_DATA_W = 32;
    localparam int unsigned SHF_AMT_W  = 8;
    localparam int unsigned SHF_FLD_W  = 4;
    localparam int unsigned SHF_SH_W   = $clog2(SHF_DATA_W);

    typedef enum logic [2:0] {
        SHF_LSL    = 3'd0,
        SHF_LSR    = 3'd1,
        SHF_ASR    = 3'd2,
        SHF_ROR    = 3'd3,
        SHF_RRX    = 3'd4,
        SHF_IMMROT = 3'd5,
        SHF_RSV6   = 3'd6,
        SHF_RSV7   = 3'd7
    } shf_kind_e;

    typedef struct packed {
        logic [SHF_DATA_W-1:0] val;
        logic                  cy;
    } shf_res_t;

    // Rotate right by s; s = 0 yields x (the left term shifts out entirely).
    function automatic logic [SHF_DATA_W-1:0] shf_rotr(
        input logic [SHF_DATA_W-1:0] x,
        input logic [SHF_SH_W-1:0]   s
    );
        logic [2*SHF_DATA_W-1:0] dbl;
        dbl = {x, x} >> s;
        return dbl[SHF_DATA_W-1:0];
    endfunction

endpackage

// File: rtl/shf_linear.sv
module shf_linear
    import shf_pkg::*;
(
    input  logic [SHF_DATA_W-1:0] opnd_i,
    input  logic [SHF_AMT_W-1:0]  amt_i,
    output shf_res_t              lsl_o,
    output shf_res_t              lsr_o,
    output shf_res_t              asr_o
);
    // Extend by one bit on the side the data leaves, so the last bit shifted
    // out lands in the extra position; amounts past the width shift it out too.
    logic [SHF_DATA_W:0] lsl_ext;
    logic [SHF_DATA_W:0] lsr_ext;
    logic [SHF_DATA_W:0] asr_ext;

    always_comb begin
        lsl_ext = {1'b0, opnd_i} << amt_i;
        lsr_ext = {opnd_i, 1'b0} >> amt_i;
        asr_ext = $unsigned($signed({opnd_i, 1'b0}) >>> amt_i);
    end

    assign lsl_o = '{val: lsl_ext[SHF_DATA_W-1:0], cy: lsl_ext[SHF_DATA_W]};
    assign lsr_o = '{val: lsr_ext[SHF_DATA_W:1],   cy: lsr_ext[0]};
    assign asr_o = '{val: asr_ext[SHF_DATA_W:1],   cy: asr_ext[0]};

endmodule

// File: rtl/shf_rotate.sv
module shf_rotate
    import shf_pkg::*;
(
    input  logic [SHF_DATA_W-1:0] opnd_i,
    input  logic [SHF_SH_W-1:0]   amt_lo_i,
    input  logic [SHF_FLD_W-1:0]  rot_fld_i,
    input  logic                  carry_i,
    output shf_res_t              ror_o,
    output shf_res_t              rrx_o,
    output shf_res_t              imm_o
);
    localparam int unsigned IMM_SH_W = SHF_FLD_W + 1;

    logic [SHF_DATA_W-1:0] ror_val;
    logic [SHF_DATA_W-1:0] imm_val;
    logic [IMM_SH_W-1:0]   imm_amt;

    // Reduced amount zero leaves the value unchanged; carry is bit 31 either way.
    assign ror_val = shf_rotr(opnd_i, amt_lo_i);
    assign ror_o   = '{val: ror_val, cy: ror_val[SHF_DATA_W-1]};

    assign rrx_o   = '{val: {carry_i, opnd_i[SHF_DATA_W-1:1]}, cy: opnd_i[0]};

    assign imm_amt = {rot_fld_i, 1'b0};
    assign imm_val = shf_rotr(opnd_i, SHF_SH_W'(imm_amt));
    // After a nonzero rotate, bit 31 holds the input bit (amount - 1).
    assign imm_o   = '{val: imm_val,
                       cy:  (rot_fld_i == '0) ? carry_i : imm_val[SHF_DATA_W-1]};

endmodule

// File: rtl/shf_outstage.sv
module shf_outstage
    import shf_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  shf_res_t d_i,
    output shf_res_t q_o
);
    generate
        if (OUT_REG) begin : g_reg
            shf_res_t q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= '0;
                else     q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_comb
            logic unused_clkrst;
            assign unused_clkrst = clk ^ rst;
            assign q_o = d_i;
        end
    endgenerate

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
    import shf_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SHF_DATA_W-1:0] opnd_i,
    input  logic [2:0]            kind_i,
    input  logic [SHF_AMT_W-1:0]  amt_i,
    input  logic [SHF_FLD_W-1:0]  rot_fld_i,
    input  logic                  carry_i,
    output logic [SHF_DATA_W-1:0] result_o,
    output logic                  carry_o
);
    localparam logic [SHF_AMT_W-1:0] AMT_FULL = SHF_AMT_W'(SHF_DATA_W);

    shf_kind_e kind;
    shf_res_t  pass_res, lsl_res, lsr_res, asr_res, ror_res, rrx_res, imm_res;
    shf_res_t  nxt, out_q;
    logic      amt_zero;

    assign kind     = shf_kind_e'(kind_i);
    assign pass_res = '{val: opnd_i, cy: carry_i};
    assign amt_zero = (amt_i == '0);

    shf_linear u_linear (
        .opnd_i (opnd_i),
        .amt_i  (amt_i),
        .lsl_o  (lsl_res),
        .lsr_o  (lsr_res),
        .asr_o  (asr_res)
    );

    shf_rotate u_rotate (
        .opnd_i    (opnd_i),
        .amt_lo_i  (amt_i[SHF_SH_W-1:0]),
        .rot_fld_i (rot_fld_i),
        .carry_i   (carry_i),
        .ror_o     (ror_res),
        .rrx_o     (rrx_res),
        .imm_o     (imm_res)
    );

    always_comb begin
        unique case (kind)
            SHF_LSL:    nxt = amt_zero ? pass_res : lsl_res;
            SHF_LSR:    nxt = amt_zero ? pass_res : lsr_res;
            SHF_ASR:    nxt = amt_zero ? pass_res : asr_res;
            SHF_ROR:    nxt = amt_zero ? pass_res : ror_res;
            SHF_RRX:    nxt = rrx_res;
            SHF_IMMROT: nxt = imm_res;
            default:    nxt = pass_res;
        endcase
    end

    shf_outstage #(.OUT_REG(OUT_REG)) u_out (
        .clk (clk),
        .rst (rst),
        .d_i (nxt),
        .q_o (out_q)
    );

    assign result_o = out_q.val;
    assign carry_o  = out_q.cy;

    // ---------------- assertions ----------------
    assert_zero_amt_R1: assert property (@(posedge clk) disable iff (rst)
        (kind_i <= 3'd3 && amt_i == '0) |-> (nxt.val == opnd_i && nxt.cy == carry_i));

    assert_lsl_lsr_beyond_R3: assert property (@(posedge clk) disable iff (rst)
        (kind_i <= 3'd1 && amt_i > AMT_FULL) |-> (nxt.val == '0 && !nxt.cy));

    assert_asr_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 3'd2 && amt_i >= AMT_FULL)
        |-> (nxt.val == {SHF_DATA_W{opnd_i[SHF_DATA_W-1]}} && nxt.cy == opnd_i[SHF_DATA_W-1]));

    assert_ror_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 3'd3 && !amt_zero && amt_i[SHF_SH_W-1:0] == '0)
        |-> (nxt.val == opnd_i && nxt.cy == opnd_i[SHF_DATA_W-1]));

    assert_rrx_R7: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 3'd4) |-> (nxt.val[SHF_DATA_W-1] == carry_i && nxt.cy == opnd_i[0]));

    assert_imm_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 3'd5 && rot_fld_i == '0) |-> (nxt.val == opnd_i && nxt.cy == carry_i));

    assert_pass_codes_R9: assert property (@(posedge clk) disable iff (rst)
        (kind_i >= 3'd6) |-> (nxt.val == opnd_i && nxt.cy == carry_i));

    generate
        if (OUT_REG) begin : g_out_chk
            logic live_q;
            always_ff @(posedge clk) live_q <= !rst;
            assert_out_latency_R10: assert property (@(posedge clk) disable iff (rst)
                live_q |-> (result_o == $past(nxt.val) && carry_o == $past(nxt.cy)));
        end
    endgenerate

endmodule

// File: tb/shf_barrel_tb.sv
`timescale 1ns/1ps
module shf_barrel_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] opnd;
    logic [2:0]  kind;
    logic [7:0]  amt;
    logic [3:0]  fld;
    logic        cin;
    logic [31:0] res;
    logic        cout;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    shf_barrel u_dut (
        .clk(clk), .rst(rst), .opnd_i(opnd), .kind_i(kind), .amt_i(amt),
        .rot_fld_i(fld), .carry_i(cin), .result_o(res), .carry_o(cout)
    );

    // Reference written from the requirement text, one rule per branch.
    function automatic logic [32:0] ref_model(input int k, input logic [31:0] x,
                                              input int a, input int f, input logic c);
        logic [31:0] r;
        logic        cy;
        int          m;
        r = x; cy = c;
        case (k)
            0: if (a != 0) begin
                   r  = (a < 32) ? (x << a) : 32'h0;
                   cy = (a <= 32) ? x[32-a] : 1'b0;
               end
            1: if (a != 0) begin
                   r  = (a < 32) ? (x >> a) : 32'h0;
                   cy = (a <= 32) ? x[a-1] : 1'b0;
               end
            2: if (a != 0) begin
                   if (a < 32) begin
                       for (int b = 0; b < 32; b++) r[b] = (b + a < 32) ? x[b+a] : x[31];
                       cy = x[a-1];
                   end else begin
                       r  = {32{x[31]}};
                       cy = x[31];
                   end
               end
            3: if (a != 0) begin
                   m = a % 32;
                   for (int b = 0; b < 32; b++) r[b] = x[(b + m) % 32];
                   cy = r[31];
               end
            4: begin r = {c, x[31:1]}; cy = x[0]; end
            5: begin
                   m = 2 * f;
                   for (int b = 0; b < 32; b++) r[b] = x[(b + m) % 32];
                   cy = (m == 0) ? c : x[m-1];
               end
            default: ;
        endcase
        return {r, cy};
    endfunction

    function automatic string tag_of(input int k, input int a);
        case (k)
            0: return (a == 0) ? "R1" : (a > 32) ? "R3" : "R2";
            1: return (a == 0) ? "R1" : (a > 32) ? "R3" : "R4";
            2: return (a == 0) ? "R1" : "R5";
            3: return (a == 0) ? "R1" : "R6";
            4: return "R7";
            5: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] ev, input logic ec);
        n_chk++;
        if (res !== ev || cout !== ec) begin
            n_fail++;
            $display("FAIL %s kind=%0d amt=%0d fld=%0d op=%h cin=%b: got %h/%b exp %h/%b",
                     tag, kind, amt, fld, opnd, cin, res, cout, ev, ec);
        end
    endtask

    // Inputs set at a falling edge, captured at the next rising edge,
    // output sampled at the following falling edge (one register stage).
    task automatic run(input int k, input logic [31:0] x, input int a,
                       input int f, input logic c);
        logic [32:0] e;
        @(negedge clk);
        kind = 3'(k); opnd = x; amt = 8'(a); fld = 4'(f); cin = c;
        e = ref_model(k, x, a, f, c);
        @(posedge clk);
        @(negedge clk);
        check(tag_of(k, a), e[32:1], e[0]);
    endtask

    logic [31:0] ops [6];

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout exp finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; kind = 3'd0; opnd = 32'hFFFF_FFFF; amt = 8'd3; fld = 4'd0; cin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", 32'h0, 1'b0); // R10: reset clears the registered outputs
        rst = 1'b0;

        ops[0] = 32'h0000_0001;
        ops[1] = 32'h8000_0001;
        ops[2] = 32'h7FFF_FFFF;
        ops[3] = 32'hFFFF_FFFF;
        ops[4] = $urandom();
        ops[5] = $urandom();

        for (int k = 0; k < 8; k++)
            for (int o = 0; o < 6; o++)
                for (int c = 0; c < 2; c++) begin
                    for (int a = 0; a <= 40; a++) run(k, ops[o], a, int'($urandom_range(15)), c[0]);
                    run(k, ops[o], 255, int'($urandom_range(15)), c[0]);
                end

        // R8: every immediate field with a random 8-bit amount present
        for (int o = 0; o < 6; o++)
            for (int c = 0; c < 2; c++)
                for (int f = 0; f < 16; f++)
                    run(5, ops[o], int'($urandom_range(255)), f, c[0]);

        // R10: back-to-back vectors keep one-cycle latency
        run(0, 32'h1, 4, 0, 1'b0);
        run(1, 32'h8000_0000, 31, 0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule